// File: doc/BRIEF.md
# Priority Interrupt Level Resolver

This block decides which interrupt level, if any, a processor core should take next. It merges a 16-bit vector of external level requests with the software-interrupt register and compares the result against the core's current priority level. It then picks the highest pending level above that priority and turns it into a hard-interrupt request with a trap-type code. The decision is registered, so both outputs follow their inputs one clock later.

A pending vector interrupt freezes the resolver, because vector interrupts outrank every level interrupt. When the core is already inside an external-interrupt trap, the resolver does not raise a new request for a level whose code is lower than the one being serviced. Trap entry and trap stacking happen elsewhere. This block only offers the request and the code.

Top module: `plr_irq_resolver`

## Requirements
- R1: While the synchronous active-low reset is asserted, `irq_req` is 0 and `trap_code` is 0, whatever the other inputs are.
- R2: The pending set is `ext_lvl` ORed with `soft_reg[15:1]` at the same bit positions. Software bit n requests level n. `soft_reg[0]` and `soft_reg[16]` never request a level at their own position.
- R3: If `soft_reg[0]` (tick match) or `soft_reg[16]` (system-tick match) is 1, level 14 is pending.
- R4: While `vec_busy` is 1, `irq_req` and `trap_code` keep their values, whatever the other inputs do.
- R5: If the pending set, read as an unsigned number, is less than 2 shifted left by `cur_lvl`, then `irq_req` becomes 0 and `trap_code` becomes 0. With `cur_lvl` = 15 this holds for any pending set.
- R6: Otherwise, with `int_en` = 1, the winner is the highest pending level above `cur_lvl`. Its code is 0x40 ORed with the level number, so codes run from 0x41 to 0x4F. Whenever `irq_req` is 1, `trap_code[8:4]` is 5'b00100 and `trap_code[3:0]` is nonzero.
- R7: If `trap_lvl` > 0, `svc_tt[8:4]` = 5'b00100 and `svc_tt` is greater than the winner's code, the outputs keep their values. If any of these three conditions fails, the winner is taken normally.
- R8: `irq_req` rises only together with a change of `trap_code`. When the winner's code equals the current `trap_code`, the outputs are held.
- R9: With `int_en` = 0 and `vec_busy` = 0, `irq_req` becomes 0 and `trap_code` becomes 0.
- R10: The outputs change only at the clock edge that follows an input change. They are one register stage behind the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_lvl | input | 16 | External level requests; bit n requests level n |
| soft_reg | input | 17 | Software interrupt bits; bit 0 is tick match, bit 16 is system-tick match, bits 15:1 are levels |
| cur_lvl | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting depth |
| svc_tt | input | 9 | Trap type currently being serviced |
| vec_busy | input | 1 | A vector interrupt is pending |
| irq_req | output | 1 | Hard-interrupt request |
| trap_code | output | 9 | Selected trap-type code, 0 when idle |

## Verification
The assertions take all inputs to be sampled, known values that stay stable around each rising edge. They rely on `svc_tt` and `trap_lvl` describing the trap in service only while the core is actually nested. They also assume that holding `vec_busy` means nothing about its duration. The stimulus changes every input only on the falling edge and holds it for a full cycle. It steps `cur_lvl` across the threshold boundaries and sets `svc_tt` both inside and outside the external-interrupt range, so every hold and clear path is reached with defined values.

// File: rtl/plr_pkg.sv
// Package: shared widths and constants for the priority level resolver.
// Assumes a level count that fits the software register layout.
package plr_pkg;
    localparam int LVL_N     = 16;
    localparam int LVL_W     = $clog2(LVL_N);
    localparam int SOFT_W    = LVL_N + 1;
    localparam int TICK_BIT  = 0;
    localparam int STICK_BIT = LVL_N;
    localparam int TIMER_LVL = 14;
    localparam int TT_W      = 9;
    localparam int TL_W      = 3;
    localparam logic [TT_W-1:0] EXT_BASE = 9'h040;

    // Combinational decision handed from the selection logic to the register.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_LOAD  = 2'd2
    } plr_act_e;
endpackage

// File: rtl/plr_pend_merge.sv
// Module: builds the pending level set from external and software bits.
// The timer-match bits do not request a level at their own positions;
// either of them requests TIMER_LVL instead. Assumes LVL_N <= SOFT_W.
module plr_pend_merge #(
    parameter int LVL_N     = 16,
    parameter int SOFT_W    = 17,
    parameter int TICK_BIT  = 0,
    parameter int STICK_BIT = 16,
    parameter int TIMER_LVL = 14
) (
    input  logic [LVL_N-1:0]  ext_lvl,
    input  logic [SOFT_W-1:0] soft_reg,
    output logic [LVL_N-1:0]  pend
);
    logic timer_hit;

    // Purpose: detect either timer-match bit.
    always_comb timer_hit = soft_reg[TICK_BIT] | soft_reg[STICK_BIT];

    for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
        logic soft_part;
        logic timer_part;
        if (g == TICK_BIT || g == STICK_BIT) begin : g_masked
            // Purpose: timer bit positions contribute no direct level.
            always_comb soft_part = 1'b0;
        end else begin : g_plain
            // Purpose: a software bit requests its own level.
            always_comb soft_part = soft_reg[g];
        end
        if (g == TIMER_LVL) begin : g_tmr
            // Purpose: fold timer matches into the timer level.
            always_comb timer_part = timer_hit;
        end else begin : g_notmr
            // Purpose: other levels ignore timer matches.
            always_comb timer_part = 1'b0;
        end
        // Purpose: merge the three sources for this level.
        always_comb pend[g] = ext_lvl[g] | soft_part | timer_part;
    end
endmodule

// File: rtl/plr_level_pick.sv
// Module: finds the highest pending level strictly above the current level.
// Purely combinational; 'found' is low when no such level exists.
module plr_level_pick #(
    parameter int LVL_N = 16,
    parameter int LVL_W = 4
) (
    input  logic [LVL_N-1:0] pend,
    input  logic [LVL_W-1:0] cur_lvl,
    output logic             found,
    output logic [LVL_W-1:0] win_lvl
);
    // Purpose: ascending scan; the last hit is the highest level.
    always_comb begin
        found   = 1'b0;
        win_lvl = '0;
        for (int i = 0; i < LVL_N; i++) begin
            if (pend[i] && (LVL_W'(i) > cur_lvl)) begin
                found   = 1'b1;
                win_lvl = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/plr_nest_guard.sv
// Module: decides whether a candidate code must wait because a higher
// external-interrupt trap is being serviced. Assumes svc_tt is only
// meaningful while trap_lvl is nonzero.
module plr_nest_guard #(
    parameter int              TT_W = 9,
    parameter int              TL_W = 3,
    parameter logic [TT_W-1:0] BASE = 9'h040
) (
    input  logic [TL_W-1:0] trap_lvl,
    input  logic [TT_W-1:0] svc_tt,
    input  logic [TT_W-1:0] cand_tt,
    output logic            block
);
    logic nested;
    logic in_ext_range;
    logic higher;

    // Purpose: classify the serviced trap and compare it with the candidate.
    always_comb begin
        nested       = (trap_lvl != '0);
        in_ext_range = (svc_tt[TT_W-1:4] == BASE[TT_W-1:4]);
        higher       = (svc_tt > cand_tt);
        block        = nested && in_ext_range && higher;
    end
endmodule

// File: rtl/plr_irq_resolver.sv
// Module: top of the priority interrupt level resolver. Merges the level
// sources, applies the priority threshold, picks the winner and registers
// the request and trap code. Assumes inputs are synchronous to clk.
module plr_irq_resolver
    import plr_pkg::*;
#(
    parameter int              P_LVL_N = plr_pkg::LVL_N,
    parameter int              P_TT_W  = plr_pkg::TT_W,
    parameter int              P_TL_W  = plr_pkg::TL_W,
    parameter logic [P_TT_W-1:0] P_BASE = plr_pkg::EXT_BASE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [P_LVL_N-1:0]    ext_lvl,
    input  logic [P_LVL_N:0]      soft_reg,
    input  logic [$clog2(P_LVL_N)-1:0] cur_lvl,
    input  logic                  int_en,
    input  logic [P_TL_W-1:0]     trap_lvl,
    input  logic [P_TT_W-1:0]     svc_tt,
    input  logic                  vec_busy,
    output logic                  irq_req,
    output logic [P_TT_W-1:0]     trap_code
);
    localparam int LW = $clog2(P_LVL_N);
    localparam int SW = P_LVL_N + 1;

    logic [P_LVL_N-1:0] pend;
    logic [P_LVL_N:0]   thr;
    logic               below;
    logic               found;
    logic [LW-1:0]      win_lvl;
    logic [P_TT_W-1:0]  cand_tt;
    logic               block;
    plr_act_e           act;

    plr_pend_merge #(
        .LVL_N(P_LVL_N), .SOFT_W(SW), .TICK_BIT(TICK_BIT),
        .STICK_BIT(P_LVL_N), .TIMER_LVL(TIMER_LVL)
    ) u_merge (
        .ext_lvl(ext_lvl), .soft_reg(soft_reg), .pend(pend)
    );

    plr_level_pick #(.LVL_N(P_LVL_N), .LVL_W(LW)) u_pick (
        .pend(pend), .cur_lvl(cur_lvl), .found(found), .win_lvl(win_lvl)
    );

    // Purpose: threshold test and candidate code.
    always_comb begin
        thr     = (P_LVL_N+1)'(2) << cur_lvl;
        below   = ({1'b0, pend} < thr);
        cand_tt = P_BASE | {{(P_TT_W-LW){1'b0}}, win_lvl};
    end

    plr_nest_guard #(.TT_W(P_TT_W), .TL_W(P_TL_W), .BASE(P_BASE)) u_guard (
        .trap_lvl(trap_lvl), .svc_tt(svc_tt), .cand_tt(cand_tt), .block(block)
    );

    // Purpose: choose what the output register does this cycle.
    always_comb begin
        act = ACT_HOLD;
        if (vec_busy) begin
            act = ACT_HOLD;
        end else if (below || !int_en) begin
            act = ACT_CLEAR;
        end else if (found && !block && (cand_tt != trap_code)) begin
            act = ACT_LOAD;
        end
    end

    // Purpose: output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req   <= 1'b0;
            trap_code <= '0;
        end else begin
            case (act)
                ACT_CLEAR: begin
                    irq_req   <= 1'b0;
                    trap_code <= '0;
                end
                ACT_LOAD: begin
                    irq_req   <= 1'b1;
                    trap_code <= cand_tt;
                end
                default: ;
            endcase
        end
    end

    // Assertions guarding the register and its inputs.
    p_timer_fold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_reg[TICK_BIT] || soft_reg[P_LVL_N]) |-> pend[TIMER_LVL]);

    p_vec_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_busy |=> ($stable(irq_req) && $stable(trap_code)));

    p_below_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_busy && below) |=> (!irq_req && trap_code == '0));

    p_code_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (trap_code[P_TT_W-1:4] == P_BASE[P_TT_W-1:4]
                     && trap_code[3:0] != 4'd0));

    p_win_above_r6: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (win_lvl > cur_lvl));

    p_nest_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_busy && !below && int_en && block) |=> $stable(trap_code));

    p_rise_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> (trap_code != $past(trap_code)));

    p_disable_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_busy && !int_en) |=> (!irq_req && trap_code == '0));
endmodule

// File: tb/test_plr_irq_resolver.sv
// Directed bench for the priority interrupt level resolver.
module test_plr_irq_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ext_lvl = '0;
    logic [16:0] soft_reg = '0;
    logic [3:0]  cur_lvl = '0;
    logic        int_en = 1'b1;
    logic [2:0]  trap_lvl = '0;
    logic [8:0]  svc_tt = '0;
    logic        vec_busy = 1'b0;
    logic        irq_req;
    logic [8:0]  trap_code;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    plr_irq_resolver i_plr_irq_resolver (
        .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .soft_reg(soft_reg),
        .cur_lvl(cur_lvl), .int_en(int_en), .trap_lvl(trap_lvl),
        .svc_tt(svc_tt), .vec_busy(vec_busy), .irq_req(irq_req),
        .trap_code(trap_code)
    );

    task automatic check(string req, logic exp_irq, logic [8:0] exp_code);
        n_chk++;
        if (irq_req !== exp_irq || trap_code !== exp_code) begin
            n_fail++;
            $display("FAIL %s: irq=%0b code=0x%0h expected irq=%0b code=0x%0h",
                     req, irq_req, trap_code, exp_irq, exp_code);
        end
    endtask

    // Apply inputs on a falling edge, return at the next falling edge.
    task automatic drive(logic [15:0] e, logic [16:0] s, logic [3:0] c,
                         logic en, logic [2:0] tl, logic [8:0] st, logic vb);
        @(negedge clk);
        ext_lvl = e; soft_reg = s; cur_lvl = c; int_en = en;
        trap_lvl = tl; svc_tt = st; vec_busy = vb;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; ext_lvl = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, 9'h000);
        ext_lvl = '0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 1'b0, 9'h000);
    endtask

    task automatic t_basic;
        drive(16'h0020, '0, 4'd0, 1'b1, '0, '0, 1'b0);
        check("R6 single level 5", 1'b1, 9'h045);
        ext_lvl = 16'h0200;
        #1 check("R10 no change before edge", 1'b1, 9'h045);
        @(negedge clk);
        check("R10 change after edge", 1'b1, 9'h049);
    endtask

    task automatic t_soft;
        drive('0, 17'h00800, 4'd0, 1'b1, '0, '0, 1'b0);
        check("R2 software level 11", 1'b1, 9'h04B);
        drive('0, 17'h00001, 4'd0, 1'b1, '0, '0, 1'b0);
        check("R3 tick match to 14", 1'b1, 9'h04E);
        drive('0, '0, 4'd0, 1'b1, '0, '0, 1'b0);
        check("R5 nothing pending", 1'b0, 9'h000);
        drive('0, 17'h10000, 4'd0, 1'b1, '0, '0, 1'b0);
        check("R3 system tick match to 14", 1'b1, 9'h04E);
        drive('0, 17'h10001, 4'd14, 1'b1, '0, '0, 1'b0);
        check("R2 timer bits below level 15 threshold", 1'b0, 9'h000);
    endtask

    task automatic t_thresh;
        drive(16'h0008, '0, 4'd3, 1'b1, '0, '0, 1'b0);
        check("R5 level equal to current", 1'b0, 9'h000);
        drive(16'h0010, '0, 4'd3, 1'b1, '0, '0, 1'b0);
        check("R5 level one above current", 1'b1, 9'h044);
        drive(16'hFFFF, '0, 4'd15, 1'b1, '0, '0, 1'b0);
        check("R5 current level 15", 1'b0, 9'h000);
    endtask

    task automatic t_prio;
        drive(16'h1088, '0, 4'd4, 1'b1, '0, '0, 1'b0);
        check("R6 highest of 3 7 12", 1'b1, 9'h04C);
        drive(16'h1088, '0, 4'd4, 1'b1, '0, '0, 1'b0);
        check("R8 same code held", 1'b1, 9'h04C);
        drive(16'h1088, '0, 4'd12, 1'b1, '0, '0, 1'b0);
        check("R5 raised current level", 1'b0, 9'h000);
    endtask

    task automatic t_enable;
        drive(16'h0040, '0, 4'd0, 1'b1, '0, '0, 1'b0);
        check("R6 level 6", 1'b1, 9'h046);
        drive(16'h0040, '0, 4'd0, 1'b0, '0, '0, 1'b0);
        check("R9 disabled clears", 1'b0, 9'h000);
        drive(16'h8000, '0, 4'd0, 1'b0, '0, '0, 1'b0);
        check("R9 disabled stays idle", 1'b0, 9'h000);
    endtask

    task automatic t_vec;
        drive(16'h0040, '0, 4'd0, 1'b1, '0, '0, 1'b0);
        check("R6 level 6 again", 1'b1, 9'h046);
        drive(16'h0400, '0, 4'd0, 1'b1, '0, '0, 1'b1);
        check("R4 busy holds code", 1'b1, 9'h046);
        drive(16'h0000, '0, 4'd0, 1'b0, '0, '0, 1'b1);
        check("R4 busy holds through clear", 1'b1, 9'h046);
        drive(16'h0000, '0, 4'd0, 1'b1, '0, '0, 1'b0);
        check("R5 clear after busy", 1'b0, 9'h000);
        drive(16'h0100, '0, 4'd0, 1'b1, '0, '0, 1'b1);
        check("R4 busy keeps idle", 1'b0, 9'h000);
        drive(16'h0100, '0, 4'd0, 1'b1, '0, '0, 1'b0);
        check("R4 release takes level 8", 1'b1, 9'h048);
    endtask

    task automatic t_nest;
        drive(16'h0080, '0, 4'd0, 1'b1, 3'd1, 9'h04A, 1'b0);
        check("R7 lower nested suppressed", 1'b1, 9'h048);
        drive(16'h0080, '0, 4'd0, 1'b1, 3'd1, 9'h043, 1'b0);
        check("R7 serviced lower, taken", 1'b1, 9'h047);
        drive(16'h0020, '0, 4'd0, 1'b1, 3'd1, 9'h06A, 1'b0);
        check("R7 serviced outside range", 1'b1, 9'h045);
        drive(16'h0008, '0, 4'd0, 1'b1, 3'd0, 9'h04A, 1'b0);
        check("R7 trap level zero", 1'b1, 9'h043);
        drive(16'h0800, '0, 4'd0, 1'b1, 3'd1, 9'h04A, 1'b0);
        check("R7 higher than serviced", 1'b1, 9'h04B);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_soft();
        t_thresh();
        t_prio();
        t_enable();
        t_vec();
        t_nest();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule